// File: doc/BRIEF.md
# Character LCD Instruction Executor

This block sits behind the host bus port of a character LCD controller. It decodes each instruction byte or data access and carries it out. It owns an 80-byte display-data memory, a 64-byte glyph memory and one shared 7-bit address counter that points into whichever memory was selected last. It also keeps a display-shift offset and the mode flags that the display scanner reads.

Every accepted operation starts a busy interval, counted in oscillator clocks. While that interval runs, the block ignores any further instruction or data access. The bus front end presents one access per strobe: the byte, a register-select bit (instruction or data) and a read/write bit. A status read (instruction select with read) never changes state. The busy flag and the address counter are visible on the ports at all times.

Top module: `char_lcd_exec`

## Requirements
- R1: After reset the address counter is 00H and the shift offset is 0. Busy is low, rd_data is 00H and the display memory is selected. The mode flags are inc_mode=1, bus_8bit=1 and all others 0. Every display-memory byte reads 20H.
- R2: The highest set bit of an instruction byte picks its class. Bit7 loads a display address, bit6 a glyph address and bit5 sets the function. Bit4 is a shift, bit3 display control, bit2 entry mode and bit1 home. 01H alone is clear. 00H does nothing and starts no busy interval.
- R3: Clear (01H) writes 20H into all 80 display bytes, sets the address counter and shift offset to 0 and selects the display memory.
- R4: Home (02H or 03H) sets the address counter and shift offset to 0 and selects the display memory. It leaves the memory contents unchanged.
- R5: After each data read or write, the counter steps up when inc_mode=1 and down when it is 0. In glyph mode the counter wraps modulo 64. In one-line display mode it wraps between 4FH and 00H. In two-line mode, 27H steps up to 40H and 67H steps up to 00H, and the reverse steps apply going down.
- R6: When auto_shift=1, each data access also moves the offset. A step up shifts it left (offset+1) and a step down shifts it right (offset-1). The span is 40 in two-line mode and 80 in one-line mode. A left shift at or beyond the span's last position gives 0. A right shift from 0, or from beyond the last position, gives the last position.
- R7: The shift instruction 0001_ab00 uses a (bit3) and b (bit2). With a=1 it shifts the display offset, right when b=1 and left when b=0. With a=0 it steps the counter, up when b=1 and down when b=0, using the wrap rules of R5.
- R8: 01aaaaaa loads the 6-bit glyph address and selects the glyph memory. 1aaaaaaa loads the 7-bit display address and selects the display memory.
- R9: A data write stores the byte at the counter's location. A data read places that byte on rd_data one clock after the strobe. In two-line mode, display addresses whose low 6 bits are 40 or more have no storage. One-line addresses of 50H and above also have no storage. Writes to such addresses are dropped, and reads from them return 00H.
- R10: Clear and home hold busy for 410 clocks. Every other instruction and every data access holds it for 10 clocks. A status read holds it for 0 clocks.
- R11: Any access other than a status read that arrives while busy is high is ignored.
- R12: Entry mode 0000_01is sets inc_mode=i and auto_shift=s. Display control 0000_1dcb sets disp_on, cursor_on and blink_on. Function set 001wnf00 sets bus_8bit=w, two_line=n and tall_font=f.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | One-clock access strobe |
| acc_rs | input | 1 | 0 instruction, 1 data |
| acc_rd | input | 1 | 1 read, 0 write |
| acc_byte | input | 8 | Instruction or write data byte |
| rd_data | output | 8 | Last data byte read |
| busy | output | 1 | Operation in progress |
| addr_ctr | output | 7 | Shared address counter |
| shift_ofs | output | 7 | Display shift offset |
| cg_select | output | 1 | 1 when the glyph memory is addressed |
| inc_mode | output | 1 | Counter steps up after data access |
| auto_shift | output | 1 | Display shifts with data access |
| disp_on | output | 1 | Display enabled |
| cursor_on | output | 1 | Cursor shown |
| blink_on | output | 1 | Cursor position blinks |
| bus_8bit | output | 1 | 8-bit host bus width selected |
| two_line | output | 1 | Two-line layout |
| tall_font | output | 1 | Tall glyph font |

## Verification
A wrong counter or wrap rule shows up on addr_ctr on the very next idle sample after a data access or shift. A wrong offset rule shows up on shift_ofs at the same sample. A wrong memory mapping stays hidden until a later read returns a wrong byte on rd_data, which can be many operations after the faulty write. The bench therefore mixes writes and read-backs across both layouts and both memories. A wrong busy duration or a lapse in the ignore rule shows at once as a changed cycle count, or as a counter or byte that moved while busy.

// File: rtl/char_lcd_pkg.sv
package char_lcd_pkg;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CLEAR,
        OP_HOME,
        OP_ENTRY,
        OP_DISP,
        OP_SHIFT,
        OP_FUNC,
        OP_CGADR,
        OP_DDADR
    } op_e;

    typedef struct packed {
        logic inc;
        logic sh;
        logic don;
        logic con;
        logic bon;
        logic dl8;
        logic two;
        logic tall;
    } mode_t;

    localparam mode_t MODE_RESET = '{inc: 1'b1, sh: 1'b0, don: 1'b0, con: 1'b0,
                                     bon: 1'b0, dl8: 1'b1, two: 1'b0, tall: 1'b0};

endpackage

// File: rtl/lcd_cmd_decode.sv
module lcd_cmd_decode
    import char_lcd_pkg::*;
(
    input  logic [7:0] code,
    output op_e        op,
    output logic       long_op
);

    always_comb begin
        casez (code)
            8'b1???????: op = OP_DDADR;
            8'b01??????: op = OP_CGADR;
            8'b001?????: op = OP_FUNC;
            8'b0001????: op = OP_SHIFT;
            8'b00001???: op = OP_DISP;
            8'b000001??: op = OP_ENTRY;
            8'b0000001?: op = OP_HOME;
            8'b00000001: op = OP_CLEAR;
            default:     op = OP_NONE;
        endcase
        long_op = (op == OP_CLEAR) || (op == OP_HOME);
    end

endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
    parameter int LONG_CLKS  = 410,
    parameter int SHORT_CLKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_sel,
    output logic busy
);

    localparam int CW = $clog2(LONG_CLKS + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = long_sel ? CW'(LONG_CLKS) : CW'(SHORT_CLKS);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R10
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (cnt_q == '0)); // R11

endmodule

// File: rtl/lcd_ram_bank.sv
module lcd_ram_bank #(
    parameter int DW       = 8,
    parameter int DD_DEPTH = 80,
    parameter int CG_DEPTH = 64,
    parameter int DD_IW    = 7,
    parameter int CG_AW    = 6,
    parameter logic [7:0] BLANK = 8'h20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             we,
    input  logic             sel_cg,
    input  logic [DD_IW-1:0] dd_idx,
    input  logic             dd_ok,
    input  logic [CG_AW-1:0] cg_idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);

    logic [DW-1:0] dd_d [DD_DEPTH];
    logic [DW-1:0] dd_q [DD_DEPTH];
    logic [DW-1:0] cg_d [CG_DEPTH];
    logic [DW-1:0] cg_q [CG_DEPTH];

    always_comb begin
        dd_d = dd_q;
        cg_d = cg_q;
        if (clear) begin
            for (int i = 0; i < DD_DEPTH; i++) dd_d[i] = DW'(BLANK);
        end else if (we) begin
            if (sel_cg)     cg_d[cg_idx] = wdata;
            else if (dd_ok) dd_d[dd_idx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DD_DEPTH; i++) dd_q[i] <= DW'(BLANK);
            for (int j = 0; j < CG_DEPTH; j++) cg_q[j] <= '0;
        end else begin
            dd_q <= dd_d;
            cg_q <= cg_d;
        end
    end

    always_comb begin
        if (sel_cg)     rdata = cg_q[cg_idx];
        else if (dd_ok) rdata = dd_q[dd_idx];
        else            rdata = '0;
    end

    AST_CLEAR_NOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !we); // R3

endmodule

// File: rtl/char_lcd_exec.sv
module char_lcd_exec
    import char_lcd_pkg::*;
#(
    parameter int AW         = 7,
    parameter int DW         = 8,
    parameter int DD_DEPTH   = 80,
    parameter int CG_DEPTH   = 64,
    parameter int LINE_LEN   = 40,
    parameter int LINE2_BASE = 64,
    parameter int LONG_CLKS  = 410,
    parameter int SHORT_CLKS = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_rs,
    input  logic          acc_rd,
    input  logic [7:0]    acc_byte,
    output logic [DW-1:0] rd_data,
    output logic          busy,
    output logic [AW-1:0] addr_ctr,
    output logic [AW-1:0] shift_ofs,
    output logic          cg_select,
    output logic          inc_mode,
    output logic          auto_shift,
    output logic          disp_on,
    output logic          cursor_on,
    output logic          blink_on,
    output logic          bus_8bit,
    output logic          two_line,
    output logic          tall_font
);

    localparam int CG_AW = $clog2(CG_DEPTH);
    localparam int DD_IW = $clog2(DD_DEPTH);
    localparam logic [AW-1:0] DD_LAST  = AW'(DD_DEPTH - 1);
    localparam logic [AW-1:0] L1_LAST  = AW'(LINE_LEN - 1);
    localparam logic [AW-1:0] L2_FIRST = AW'(LINE2_BASE);
    localparam logic [AW-1:0] L2_LAST  = AW'(LINE2_BASE + LINE_LEN - 1);
    localparam logic [AW-1:0] LLEN     = AW'(LINE_LEN);
    localparam logic [AW-1:0] DDEP     = AW'(DD_DEPTH);

    typedef struct packed {
        logic [AW-1:0] ac;
        logic [AW-1:0] ofs;
        logic          cg;
        mode_t         mode;
        logic [DW-1:0] rd;
    } state_t;

    state_t st_d, st_q;

    op_e              op;
    logic             long_op;
    logic             is_status, take, ram_we, ram_clear;
    logic [DW-1:0]    ram_rdata;
    logic [DD_IW-1:0] dd_idx;
    logic             dd_ok;
    logic [AW-1:0]    dd_off;
    logic             dd_line2;

    function automatic logic [AW-1:0] ac_step(input logic [AW-1:0] a, input logic up,
                                              input logic cg, input logic two);
        logic [CG_AW-1:0] c;
        logic [AW-1:0]    r;
        c = a[CG_AW-1:0];
        if (cg) begin
            c = up ? c + 1'b1 : c - 1'b1;
            r = AW'(c);
        end else if (two) begin
            if (up) r = (a == L1_LAST) ? L2_FIRST : (a == L2_LAST) ? '0 : a + 1'b1;
            else    r = (a == '0) ? L2_LAST : (a == L2_FIRST) ? L1_LAST : a - 1'b1;
        end else begin
            if (up) r = (a >= DD_LAST) ? '0 : a + 1'b1;
            else    r = (a == '0) ? DD_LAST : a - 1'b1;
        end
        return r;
    endfunction

    function automatic logic [AW-1:0] ofs_step(input logic [AW-1:0] o, input logic left,
                                               input logic two);
        logic [AW-1:0] last;
        last = two ? L1_LAST : DD_LAST;
        if (left) return (o >= last) ? '0 : o + 1'b1;
        else      return ((o == '0) || (o > last)) ? last : o - 1'b1;
    endfunction

    lcd_cmd_decode i_decode (
        .code    (acc_byte),
        .op      (op),
        .long_op (long_op)
    );

    assign is_status = !acc_rs && acc_rd;
    assign take      = acc_valid && !busy && !is_status && (acc_rs || (op != OP_NONE));
    assign ram_we    = take && acc_rs && !acc_rd;
    assign ram_clear = take && !acc_rs && (op == OP_CLEAR);

    lcd_busy_timer #(
        .LONG_CLKS  (LONG_CLKS),
        .SHORT_CLKS (SHORT_CLKS)
    ) i_busy (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (take),
        .long_sel (!acc_rs && long_op),
        .busy     (busy)
    );

    always_comb begin
        dd_line2 = st_q.mode.two && (st_q.ac >= L2_FIRST);
        dd_off   = dd_line2 ? st_q.ac - L2_FIRST : st_q.ac;
        if (st_q.mode.two) begin
            dd_ok  = dd_off < LLEN;
            dd_idx = dd_line2 ? DD_IW'(dd_off) + DD_IW'(LINE_LEN) : DD_IW'(dd_off);
        end else begin
            dd_ok  = st_q.ac < DDEP;
            dd_idx = DD_IW'(st_q.ac);
        end
    end

    lcd_ram_bank #(
        .DW       (DW),
        .DD_DEPTH (DD_DEPTH),
        .CG_DEPTH (CG_DEPTH),
        .DD_IW    (DD_IW),
        .CG_AW    (CG_AW)
    ) i_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (ram_clear),
        .we     (ram_we),
        .sel_cg (st_q.cg),
        .dd_idx (dd_idx),
        .dd_ok  (dd_ok),
        .cg_idx (st_q.ac[CG_AW-1:0]),
        .wdata  (DW'(acc_byte)),
        .rdata  (ram_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (take) begin
            if (acc_rs) begin
                if (acc_rd) st_d.rd = ram_rdata;
                st_d.ac = ac_step(st_q.ac, st_q.mode.inc, st_q.cg, st_q.mode.two);
                if (st_q.mode.sh) st_d.ofs = ofs_step(st_q.ofs, st_q.mode.inc, st_q.mode.two);
            end else begin
                case (op)
                    OP_CLEAR, OP_HOME: begin
                        st_d.ac  = '0;
                        st_d.ofs = '0;
                        st_d.cg  = 1'b0;
                    end
                    OP_ENTRY: begin
                        st_d.mode.inc = acc_byte[1];
                        st_d.mode.sh  = acc_byte[0];
                    end
                    OP_DISP: begin
                        st_d.mode.don = acc_byte[2];
                        st_d.mode.con = acc_byte[1];
                        st_d.mode.bon = acc_byte[0];
                    end
                    OP_SHIFT: begin
                        if (acc_byte[3]) st_d.ofs = ofs_step(st_q.ofs, !acc_byte[2], st_q.mode.two);
                        else             st_d.ac  = ac_step(st_q.ac, acc_byte[2], st_q.cg, st_q.mode.two);
                    end
                    OP_FUNC: begin
                        st_d.mode.dl8  = acc_byte[4];
                        st_d.mode.two  = acc_byte[3];
                        st_d.mode.tall = acc_byte[2];
                    end
                    OP_CGADR: begin
                        st_d.ac = AW'(acc_byte[CG_AW-1:0]);
                        st_d.cg = 1'b1;
                    end
                    OP_DDADR: begin
                        st_d.ac = acc_byte[AW-1:0];
                        st_d.cg = 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ac   <= '0;
            st_q.ofs  <= '0;
            st_q.cg   <= 1'b0;
            st_q.mode <= MODE_RESET;
            st_q.rd   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data    = st_q.rd;
    assign addr_ctr   = st_q.ac;
    assign shift_ofs  = st_q.ofs;
    assign cg_select  = st_q.cg;
    assign inc_mode   = st_q.mode.inc;
    assign auto_shift = st_q.mode.sh;
    assign disp_on    = st_q.mode.don;
    assign cursor_on  = st_q.mode.con;
    assign blink_on   = st_q.mode.bon;
    assign bus_8bit   = st_q.mode.dl8;
    assign two_line   = st_q.mode.two;
    assign tall_font  = st_q.mode.tall;

    AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && busy) |=> ($stable(addr_ctr) && $stable(shift_ofs) && $stable(cg_select)
                                 && $stable(rd_data))); // R11
    AST_CG_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cg_select |-> (addr_ctr < AW'(CG_DEPTH))); // R8
    AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_ofs < DDEP); // R6
    AST_HOME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !acc_rs && long_op) |=> ((addr_ctr == '0) && (shift_ofs == '0) && !cg_select)); // R4
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy); // R10

endmodule

// File: tb/test_char_lcd_exec.sv
module test_char_lcd_exec;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic       acc_rs = 1'b0;
    logic       acc_rd = 1'b0;
    logic [7:0] acc_byte = 8'h00;
    logic [7:0] rd_data;
    logic       busy;
    logic [6:0] addr_ctr, shift_ofs;
    logic       cg_select, inc_mode, auto_shift, disp_on, cursor_on, blink_on;
    logic       bus_8bit, two_line, tall_font;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    char_lcd_exec i_char_lcd_exec (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_rs(acc_rs),
        .acc_rd(acc_rd), .acc_byte(acc_byte), .rd_data(rd_data), .busy(busy),
        .addr_ctr(addr_ctr), .shift_ofs(shift_ofs), .cg_select(cg_select),
        .inc_mode(inc_mode), .auto_shift(auto_shift), .disp_on(disp_on),
        .cursor_on(cursor_on), .blink_on(blink_on), .bus_8bit(bus_8bit),
        .two_line(two_line), .tall_font(tall_font)
    );

    // reference model state
    logic [7:0] m_dd [80];
    logic [7:0] m_cgm [64];
    logic [6:0] m_ac, m_ofs;
    logic       m_cg;
    logic [7:0] m_mode;   // {inc, sh, don, con, bon, dl8, two, tall}
    logic [7:0] m_rd;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mode_vec();
        return {inc_mode, auto_shift, disp_on, cursor_on, blink_on, bus_8bit, two_line, tall_font};
    endfunction

    function automatic logic [6:0] b_step(input logic [6:0] a, input logic up);
        logic [5:0] c;
        if (m_cg) begin
            c = a[5:0];
            c = up ? c + 6'd1 : c - 6'd1;
            return {1'b0, c};
        end
        if (m_mode[1]) begin
            if (up) begin
                if (a == 7'h27) return 7'h40;
                if (a == 7'h67) return 7'h00;
                return a + 7'd1;
            end
            if (a == 7'h00) return 7'h67;
            if (a == 7'h40) return 7'h27;
            return a - 7'd1;
        end
        if (up) return (a >= 7'h4F) ? 7'h00 : a + 7'd1;
        return (a == 7'h00) ? 7'h4F : a - 7'd1;
    endfunction

    function automatic logic [6:0] b_ofs(input logic [6:0] o, input logic left);
        int last;
        last = m_mode[1] ? 39 : 79;
        if (left) return (int'(o) >= last) ? 7'd0 : o + 7'd1;
        return (o == 0 || int'(o) > last) ? 7'(last) : o - 7'd1;
    endfunction

    function automatic int b_idx(input logic [6:0] a);
        int lo;
        if (!m_mode[1]) return (a < 80) ? int'(a) : -1;
        lo = int'(a[5:0]);
        if (a >= 7'h40) lo = int'(a) - 64;
        else lo = int'(a);
        if (lo >= 40) return -1;
        return (a >= 7'h40) ? 40 + lo : lo;
    endfunction

    task automatic model(input logic rs, input logic rd, input logic [7:0] b, output int dur);
        int ix;
        dur = 0;
        if (!rs && rd) return;
        if (rs) begin
            dur = 10;
            ix = b_idx(m_ac);
            if (rd) begin
                if (m_cg)         m_rd = m_cgm[m_ac[5:0]];
                else if (ix >= 0) m_rd = m_dd[ix];
                else              m_rd = 8'h00;
            end else begin
                if (m_cg)         m_cgm[m_ac[5:0]] = b;
                else if (ix >= 0) m_dd[ix] = b;
            end
            m_ac = b_step(m_ac, m_mode[7]);
            if (m_mode[6]) m_ofs = b_ofs(m_ofs, m_mode[7]);
            return;
        end
        dur = 10;
        if (b[7]) begin m_ac = b[6:0]; m_cg = 1'b0; end
        else if (b[6]) begin m_ac = {1'b0, b[5:0]}; m_cg = 1'b1; end
        else if (b[5]) m_mode[2:0] = b[4:2];
        else if (b[4]) begin
            if (b[3]) m_ofs = b_ofs(m_ofs, !b[2]);
            else      m_ac = b_step(m_ac, b[2]);
        end
        else if (b[3]) m_mode[5:3] = b[2:0];
        else if (b[2]) m_mode[7:6] = b[1:0];
        else if (b[1]) begin dur = 410; m_ac = 0; m_ofs = 0; m_cg = 0; end
        else if (b[0]) begin
            dur = 410; m_ac = 0; m_ofs = 0; m_cg = 0;
            for (int i = 0; i < 80; i++) m_dd[i] = 8'h20;
        end
        else dur = 0;
    endtask

    task automatic do_acc(input logic rs, input logic rd, input logic [7:0] b, output int n);
        @(negedge clk);
        acc_valid = 1'b1; acc_rs = rs; acc_rd = rd; acc_byte = b;
        @(negedge clk);
        acc_valid = 1'b0;
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run(input logic rs, input logic rd, input logic [7:0] b, input string tag);
        int n, dur;
        model(rs, rd, b, dur);
        do_acc(rs, rd, b, n);
        chk("R10", n, dur);
        chk(tag, addr_ctr, m_ac);
        chk(tag, shift_ofs, m_ofs);
        chk("R8", cg_select, m_cg);
        chk("R12", mode_vec(), m_mode);
        if (rs && rd) chk("R9", rd_data, m_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL R10: watchdog expired, actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] b;
        int sel;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 80; i++) m_dd[i] = 8'h20;
        for (int i = 0; i < 64; i++) m_cgm[i] = 8'h00;
        m_ac = 0; m_ofs = 0; m_cg = 0; m_mode = 8'b1000_0100; m_rd = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", addr_ctr, 0);
        chk("R1", shift_ofs, 0);
        chk("R1", busy, 0);
        chk("R1", rd_data, 0);
        chk("R1", cg_select, 0);
        chk("R1", mode_vec(), 8'b1000_0100);
        run(1, 1, 8'h00, "R1");
        chk("R1", rd_data, 8'h20);

        // R2 decode: 00H is a no-op, 03H is home, status read costs nothing
        run(0, 0, 8'h00, "R2");
        run(1, 0, 8'h41, "R9");
        run(0, 0, 8'h03, "R2");
        run(0, 1, 8'h5A, "R10");
        run(0, 0, 8'h07, "R2");
        run(0, 0, 8'h06, "R2");

        // R5 one-line wrap 4FH -> 00H, with auto-shift R6
        run(0, 0, 8'hCF, "R8");
        run(0, 0, 8'h07, "R12");
        run(1, 0, 8'h11, "R5");
        run(1, 0, 8'h22, "R6");
        run(0, 0, 8'h06, "R12");
        run(0, 0, 8'hCF, "R8");
        run(1, 1, 8'h00, "R9");

        // R5 two-line jumps
        run(0, 0, 8'h38, "R12");
        run(0, 0, 8'hA7, "R8");
        run(1, 0, 8'h5C, "R5");
        run(0, 0, 8'hE7, "R8");
        run(1, 0, 8'h6D, "R5");
        run(0, 0, 8'h04, "R12");
        run(1, 1, 8'h00, "R5");
        run(0, 0, 8'hC0, "R8");
        run(1, 1, 8'h00, "R5");
        // R9 address without storage in two-line mode
        run(0, 0, 8'hB0, "R8");
        run(0, 0, 8'h06, "R12");
        run(1, 0, 8'h99, "R9");
        run(0, 0, 8'hB0, "R8");
        run(1, 1, 8'h00, "R9");

        // R6/R7 display shift at span edges, then R7 cursor moves
        run(0, 0, 8'h18, "R7");
        run(0, 0, 8'h1C, "R7");
        run(0, 0, 8'h1C, "R7");
        run(0, 0, 8'h10, "R7");
        run(0, 0, 8'h14, "R7");

        // R5 glyph memory wraps modulo 64
        run(0, 0, 8'h7F, "R8");
        run(1, 0, 8'hA5, "R5");
        run(0, 0, 8'h7F, "R8");
        run(1, 1, 8'h00, "R9");

        // R4 home keeps data
        run(0, 0, 8'h02, "R4");
        run(1, 1, 8'h00, "R4");

        // R11 accesses while busy are ignored
        model(0, 0, 8'h01, n);
        @(negedge clk);
        acc_valid = 1'b1; acc_rs = 1'b0; acc_rd = 1'b0; acc_byte = 8'h01;
        @(negedge clk);
        acc_valid = 1'b0;
        repeat (4) @(negedge clk);
        acc_valid = 1'b1; acc_rs = 1'b0; acc_rd = 1'b0; acc_byte = 8'hC5;
        @(negedge clk);
        acc_rs = 1'b1; acc_byte = 8'h77;
        @(negedge clk);
        acc_valid = 1'b0;
        chk("R11", addr_ctr, 0);
        chk("R11", busy, 1);
        while (busy) @(negedge clk);
        chk("R11", addr_ctr, 0);
        run(1, 1, 8'h00, "R11");
        chk("R3", rd_data, 8'h20);

        // R3 clear after writes
        run(1, 0, 8'h33, "R9");
        run(0, 0, 8'h01, "R3");
        run(1, 1, 8'h00, "R3");

        // constrained random mix
        for (int k = 0; k < 400; k++) begin
            sel = int'($urandom_range(0, 99));
            if (sel < 28)      run(1, 0, 8'($urandom), "R9");
            else if (sel < 48) run(1, 1, 8'h00, "R5");
            else if (sel < 60) run(0, 0, 8'h80 | 8'($urandom_range(0, 127)), "R8");
            else if (sel < 66) run(0, 0, 8'h40 | 8'($urandom_range(0, 63)), "R8");
            else if (sel < 74) run(0, 0, 8'h04 | 8'($urandom_range(0, 3)), "R12");
            else if (sel < 83) run(0, 0, 8'h10 | 8'($urandom_range(0, 15)), "R7");
            else if (sel < 87) run(0, 0, 8'h08 | 8'($urandom_range(0, 7)), "R12");
            else if (sel < 93) run(0, 0, 8'h20 | 8'($urandom_range(0, 31)), "R12");
            else if (sel < 96) run(0, 0, 8'h02 | 8'($urandom_range(0, 1)), "R4");
            else if (sel < 97) run(0, 0, 8'h01, "R3");
            else begin
                b = 8'($urandom);
                run(0, 1, b, "R10");
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule